// File: doc/BRIEF.md
# Video Line Sync Detector with Flywheel

This block watches a stream of 10-bit parallel video words. It finds timing reference sequences: an all-ones word followed by two all-zero words. It keeps a flywheel counter that predicts the word in which the next sequence should complete. Every detected sequence flips the `hsync` output. A sequence at the wrong position, or a predicted position that passes with no sequence, counts as a sync error. Each error gives a one-cycle pulse on `sync_err`.

The `corr_en` input sets how much the flywheel trusts a single bad sync. When it is high, one isolated error is tolerated, and the counter realigns only when a further misplaced sequence arrives while the error is still pending. When it is low, every sequence realigns the counter at once. A sliding window over the most recent lines tracks how many lines held an error. The `sync_warn` output is raised when that count reaches a threshold.

The input is a valid/ready stream. `in_ready` is held high at all times, so the block never applies back-pressure. A word is consumed in every cycle where `in_valid` is high. While `in_valid` is low, the word bus is ignored and no state advances.

Top module: `vsync_flywheel`

## Requirements
- R1: A sequence is detected on the third of three consecutively accepted words 0x3FF, 0x000, 0x000. Any other third word, such as 0x001, is not a detection.
- R2: `hsync` flips level in the cycle after each detection and holds its level in every other cycle.
- R3: `in_ready` is always high. Cycles with `in_valid` low change no state and produce no detection or error, whatever the word bus carries.
- R4: The flywheel position counts accepted words modulo LINE_LEN. A detection whose third word arrives at position LINE_LEN-1 is a match.
- R5: `sync_err` pulses for one cycle after either of two kinds of accepted word: a misplaced detection, or a word at position LINE_LEN-1 that carries no detection.
- R6: With `corr_en` low, every detection sets the position of the next accepted word to 0.
- R7: With `corr_en` high and no error pending, an error does not move the flywheel and marks an error as pending. A missing sequence also leaves an existing pending mark set.
- R8: With `corr_en` high and an error pending, a misplaced detection realigns the flywheel to that sequence and clears the pending mark.
- R9: A matching detection clears the pending mark.
- R10: A line ends on an accepted word at position LINE_LEN-1 or on a realignment. At each line end, the errored/clean status of the last WIN_LINES lines is updated. `sync_warn` rises when the count of errored lines reaches THRESH.
- R11: Once raised, `sync_warn` falls after WIN_LINES consecutive line ends whose count is below THRESH. It changes only at line ends.
- R12: Synchronous active-high `rst` clears the flywheel, the pending mark and the window, and drives `hsync`, `sync_warn` and `sync_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_word` is offered this cycle |
| in_ready | output | 1 | Always high; the block accepts every offered word |
| in_word | input | WORD_W | Parallel video word |
| corr_en | input | 1 | High: tolerate one isolated sync error before realigning |
| hsync | output | 1 | Flips once per detected sequence |
| sync_warn | output | 1 | Error-rate warning, active high |
| sync_err | output | 1 | One-cycle pulse per sync error |

## Verification
Lines are driven with the sequence at the predicted word, at an earlier word, or missing entirely. Each line also carries an idle cycle whose bus holds sync-like values. Runs of misplaced lines under correction show the difference between one tolerated error and a realignment, because a second error in the same line appears only if the flywheel stayed put. A match placed between two bad lines shows whether the pending mark was cleared. The same misplacements with correction off show immediate realignment. Error-line densities just above and below the threshold, followed by a clean stretch, fix the exact line end where the warning rises and where it falls.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  typedef struct packed {
    logic match;
    logic misplaced;
    logic missing;
  } vsf_evt_t;

  function automatic int unsigned vsf_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vsf_trs_detect.sv
module vsf_trs_detect #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic              hsync
);
  localparam logic [WORD_W-1:0] LEAD = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] ZERO = {WORD_W{1'b0}};

  logic [WORD_W-1:0] prev1, prev2;

  assign hit = acc && (prev2 == LEAD) && (prev1 == ZERO) && (word == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev1 <= ZERO;
      prev2 <= ZERO;
      hsync <= 1'b0;
    end else begin
      if (acc) begin
        prev1 <= word;
        prev2 <= prev1;
      end
      if (hit) hsync <= ~hsync;
    end
  end
endmodule

// File: rtl/vsf_flywheel.sv
module vsf_flywheel
  import vsf_pkg::*;
#(
  parameter int unsigned LINE_LEN = 1716,
  localparam int unsigned POS_W = vsf_cnt_w(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             hit,
  input  logic             corr_en,
  output vsf_evt_t         evt,
  output logic             err,
  output logic             line_end,
  output logic [POS_W-1:0] pos,
  output logic             pend
);
  localparam logic [POS_W-1:0] LAST = POS_W'(LINE_LEN - 1);

  logic at_last, realign;

  always_comb begin
    at_last       = (pos == LAST);
    evt.match     = acc && hit && at_last;
    evt.misplaced = acc && hit && !at_last;
    evt.missing   = acc && !hit && at_last;
    realign       = evt.misplaced && (!corr_en || pend);
    err           = evt.misplaced || evt.missing;
    line_end      = acc && (at_last || realign);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      pend <= 1'b0;
    end else if (acc) begin
      pos <= (at_last || realign) ? '0 : pos + 1'b1;
      if (!corr_en || evt.match || realign) pend <= 1'b0;
      else if (err)                         pend <= 1'b1;
    end
  end
endmodule

// File: rtl/vsf_err_window.sv
module vsf_err_window #(
  parameter int unsigned WIN_LINES = 16,
  parameter int unsigned THRESH    = 4,
  localparam int unsigned QW = $clog2(WIN_LINES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic err,
  input  logic line_end,
  output logic warn
);
  logic [WIN_LINES-1:0] hist, hist_n;
  logic [QW-1:0]        quiet;
  logic                 seg_err, bit_now;
  int unsigned          cnt_n;

  always_comb begin
    bit_now = seg_err || err;
    hist_n  = {hist[WIN_LINES-2:0], bit_now};
    cnt_n   = $countones(hist_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      quiet   <= '0;
      warn    <= 1'b0;
      seg_err <= 1'b0;
    end else begin
      if (line_end)  seg_err <= 1'b0;
      else if (err)  seg_err <= 1'b1;
      if (line_end) begin
        hist <= hist_n;
        if (cnt_n >= THRESH) begin
          warn  <= 1'b1;
          quiet <= '0;
        end else if (warn) begin
          if (quiet == QW'(WIN_LINES - 1)) begin
            warn  <= 1'b0;
            quiet <= '0;
          end else begin
            quiet <= quiet + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vsync_flywheel.sv
module vsync_flywheel
  import vsf_pkg::*;
#(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned LINE_LEN  = 1716,
  parameter int unsigned WIN_LINES = 16,
  parameter int unsigned THRESH    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              corr_en,
  output logic              hsync,
  output logic              sync_warn,
  output logic              sync_err
);
  localparam int unsigned POS_W = vsf_cnt_w(LINE_LEN);

  logic             acc, trs_hit, fly_err, line_end, fly_pend;
  logic [POS_W-1:0] fly_pos;
  vsf_evt_t         fly_evt;

  assign in_ready = 1'b1;
  assign acc      = in_valid;

  vsf_trs_detect #(.WORD_W(WORD_W)) u_det (
    .clk(clk), .rst(rst), .acc(acc), .word(in_word),
    .hit(trs_hit), .hsync(hsync)
  );

  vsf_flywheel #(.LINE_LEN(LINE_LEN)) u_fly (
    .clk(clk), .rst(rst), .acc(acc), .hit(trs_hit), .corr_en(corr_en),
    .evt(fly_evt), .err(fly_err), .line_end(line_end),
    .pos(fly_pos), .pend(fly_pend)
  );

  vsf_err_window #(.WIN_LINES(WIN_LINES), .THRESH(THRESH)) u_win (
    .clk(clk), .rst(rst), .err(fly_err), .line_end(line_end), .warn(sync_warn)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_err <= 1'b0;
    else     sync_err <= fly_err;
  end
endmodule

// File: rtl/vsync_flywheel_chk.sv
module vsync_flywheel_chk #(
  parameter int unsigned LINE_LEN = 1716,
  parameter int unsigned POS_W    = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             corr_en,
  input logic             trs_hit,
  input logic             line_end,
  input logic [POS_W-1:0] pos,
  input logic             pend,
  input logic             hsync,
  input logic             sync_warn,
  input logic             sync_err
);
  localparam logic [POS_W-1:0] LAST = POS_W'(LINE_LEN - 1);

  a_r2_hsync_flip: assert property (@(posedge clk) disable iff (rst)
    trs_hit |=> (hsync != $past(hsync)));
  a_r2_hsync_hold: assert property (@(posedge clk) disable iff (rst)
    !trs_hit |=> $stable(hsync));
  a_r3_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(pos) && $stable(pend)));
  a_r4_pos_range: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST);
  a_r5_err_needs_word: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !sync_err);
  a_r6_realign_now: assert property (@(posedge clk) disable iff (rst)
    (!corr_en && trs_hit) |=> (pos == '0));
  a_r7_first_err_kept: assert property (@(posedge clk) disable iff (rst)
    (corr_en && trs_hit && !pend && pos != LAST) |=> (pend && pos == $past(pos) + 1'b1));
  a_r8_second_realigns: assert property (@(posedge clk) disable iff (rst)
    (corr_en && trs_hit && pend && pos != LAST) |=> (!pend && pos == '0));
  a_r9_match_clears: assert property (@(posedge clk) disable iff (rst)
    (trs_hit && pos == LAST) |=> !pend);
  a_r11_warn_at_line_end: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(sync_warn));
  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (!hsync && !sync_warn && !sync_err && !pend && pos == '0));
endmodule

bind vsync_flywheel vsync_flywheel_chk #(.LINE_LEN(LINE_LEN), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .corr_en(corr_en),
  .trs_hit(trs_hit), .line_end(line_end), .pos(fly_pos), .pend(fly_pend),
  .hsync(hsync), .sync_warn(sync_warn), .sync_err(sync_err)
);

// File: tb/vsync_flywheel_bench.sv
module vsync_flywheel_bench;
  localparam int LINE = 16;
  localparam int NV   = 18;
  localparam int NONE = 31;

  // {corr_en, trs index in line (31 = none), expected sync_err pulses, expected warn}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 5'd15, 2'd0, 1'b0},  // R4 aligned
    {1'b1, 5'd15, 2'd0, 1'b0},
    {1'b1, 5'd9,  2'd2, 1'b0},  // R7 tolerated, then missing
    {1'b1, 5'd15, 2'd0, 1'b0},  // R9 match clears pending
    {1'b1, 5'd9,  2'd2, 1'b1},  // R7 again, R10 rises
    {1'b1, 5'd9,  2'd1, 1'b1},  // R8 realign
    {1'b1, 5'd9,  2'd0, 1'b1},
    {1'b1, 5'd9,  2'd0, 1'b1},
    {1'b1, 5'd9,  2'd0, 1'b1},  // R11 quiet 1
    {1'b1, 5'd9,  2'd0, 1'b1},
    {1'b1, 5'd9,  2'd0, 1'b1},
    {1'b1, 5'd9,  2'd0, 1'b0},  // R11 falls
    {1'b0, 5'd3,  2'd1, 1'b0},  // R6 immediate realign
    {1'b0, 5'd3,  2'd0, 1'b0},
    {1'b0, 5'd31, 2'd1, 1'b1},  // R5 missing sync, R10
    {1'b1, 5'd3,  2'd0, 1'b1},
    {1'b1, 5'd12, 2'd2, 1'b1},  // R7 pending from missing, R8 realign
    {1'b1, 5'd12, 2'd0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [9:0] in_word = 10'h200;
  logic       corr_en = 1'b1;
  logic       in_ready, hsync, sync_warn, sync_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  exp_hs = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  vsync_flywheel #(.WORD_W(10), .LINE_LEN(LINE), .WIN_LINES(4), .THRESH(2)) u_vsync_flywheel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .corr_en(corr_en), .hsync(hsync), .sync_warn(sync_warn), .sync_err(sync_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_word(input bit v, input logic [9:0] w, inout int errs);
    @(negedge clk);
    in_valid = v;
    in_word  = w;
    @(posedge clk);
    #2;
    if (sync_err) errs++;
  endtask

  task automatic send_line(input bit corr, input int idx, input bit bad, output int errs);
    errs = 0;
    corr_en = corr;
    for (int i = 0; i < LINE; i++) begin
      logic [9:0] w;
      w = 10'h200;
      if (idx >= 2) begin
        if (i == idx - 2) w = 10'h3FF;
        if (i == idx - 1) w = 10'h000;
        if (i == idx)     w = bad ? 10'h001 : 10'h000;
      end
      drive_word(1'b1, w, errs);
      if (i == 0) drive_word(1'b0, 10'h3FF, errs);  // R3 idle cycle with sync-like bus
    end
    if (idx >= 2 && !bad) exp_hs = ~exp_hs;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int errs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 hsync", hsync, 0);
    check("R12 sync_warn", sync_warn, 0);
    check("R3 in_ready", in_ready, 1);

    for (int v = 0; v < NV; v++) begin
      int idx;
      idx = (VEC[v][7:3] == 5'(NONE)) ? -1 : int'(VEC[v][7:3]);
      send_line(VEC[v][8], idx, 1'b0, errs);
      check("R5 R7 R8 R6 sync_err count", errs, int'(VEC[v][2:1]));
      check("R2 hsync level", hsync, exp_hs);
      check("R10 R11 sync_warn", sync_warn, int'(VEC[v][0]));
    end

    // R12 reset while warning is high
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check("R12 hsync after reset", hsync, 0);
    check("R12 warn after reset", sync_warn, 0);
    check("R12 sync_err after reset", sync_err, 0);
    @(negedge clk);
    rst = 1'b0;
    exp_hs = 1'b0;

    // R7 R8 R4 from a fresh flywheel
    send_line(1'b1, 7, 1'b0, errs);
    check("R7 fresh first error held", errs, 2);
    send_line(1'b1, 7, 1'b0, errs);
    check("R8 fresh realign", errs, 1);
    check("R10 fresh warn", sync_warn, 1);
    send_line(1'b1, 7, 1'b0, errs);
    check("R4 fresh aligned", errs, 0);
    check("R2 fresh hsync", hsync, exp_hs);

    // R3 sync pattern on idle cycles is ignored
    errs = 0;
    drive_word(1'b0, 10'h3FF, errs);
    drive_word(1'b0, 10'h000, errs);
    drive_word(1'b0, 10'h000, errs);
    check("R3 idle no error", errs, 0);
    check("R3 idle hsync", hsync, exp_hs);

    // R1 near-miss pattern is not a sync
    send_line(1'b0, 7, 1'b1, errs);
    check("R1 near miss gives missing error", errs, 1);
    check("R1 near miss hsync", hsync, exp_hs);

    finish_run();
  end
endmodule